// File: doc/BRIEF.md
# Hardware Sprite Pixel Compositor

The compositor answers one question per beam position: which of sixteen 16x16 hardware sprites is visible at that pixel, and what colour it shows. The caller presents a beam coordinate with a valid strobe. Two clock cycles later the block returns a valid flag, the 4-bit pen of the winning sprite and the 12-bit colour taken from a dedicated 15-entry sprite palette. When no sprite covers the pixel with an opaque pen, the result is transparent. Beam timing and blending with the background belong to the surrounding video logic.

Each sprite has its own position and its own horizontal and vertical magnification. Writing a magnification code of zero removes a sprite from the picture without touching its pixels or position. Software uses this to keep sprites off a status panel. A byte-wide write port loads the pixel memories, the per-sprite attributes and the palette.

Top module: `spr_compositor`

## Requirements
- R1: After reset every magnification field is zero, so every sprite is hidden and `px_valid`, `px_pen` and `px_colour` read 0.
- R2: Pixel memory is written at addresses 0x000-0xFFF, where address = sprite*256 + row*16 + col and `cpu_wdata[3:0]` is the pen. At x1 size a sprite placed at (X, Y) shows pixel (row = beam_y-Y, col = beam_x-X) for beam positions X..X+15 and Y..Y+15.
- R3: Bits 3..2 of the magnification byte are the horizontal code and bits 1..0 are the vertical code. Codes 1, 2 and 3 scale that axis by 1, 2 and 4. The covered index is (beam - position) shifted right by 0, 1 or 2.
- R4: If either magnification code of a sprite is zero, that sprite never contributes a pixel.
- R5: Pen 0 is transparent. A covered pixel with pen 0 lets a higher-numbered sprite underneath show through, and if none does the result is invalid.
- R6: Where several sprites cover a pixel with non-zero pens, the lowest-numbered sprite wins.
- R7: Palette entry for pen p (1..15) is written at 0x1122 + 2*(p-1) (low byte = {R,B}) and the next address (bits 3..0 = G). `px_colour` is {G,R,B} of the winning pen's current entry.
- R8: Sprite s attributes sit at 0x1000 + 8*s. Offset +0/+1 are X low/high, +2/+3 are Y low/high, +4 is magnification, and writes to offsets +5..+7 change nothing.
- R9: Coordinates compare modulo 2^16, so a sprite near 0xFFFF wraps around onto coordinate 0.
- R10: The result for a beam sample appears exactly two clock cycles after it. A cycle with `beam_valid` low gives `px_valid` low two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Write strobe for the configuration port |
| cpu_addr | input | 13 | Write address (pixel memory, attributes, palette) |
| cpu_wdata | input | 8 | Write data byte |
| beam_valid | input | 1 | Beam coordinate is valid this cycle |
| beam_x | input | 16 | Beam horizontal coordinate |
| beam_y | input | 16 | Beam vertical coordinate |
| px_valid | output | 1 | An opaque sprite pixel covers the sampled position |
| px_pen | output | 4 | Pen of the winning sprite, 0 when transparent |
| px_colour | output | 12 | Palette colour {G,R,B}, 0 when transparent |

## Verification
The bench sweeps whole rectangles of beam positions and compares every pixel against an arithmetic model. The sweeps use four layouts. A lone unit-size sprite pins the coordinate-to-address mapping and its edges. Three overlapping sprites with mixed x2 and x4 factors separate the per-axis shift and the priority order, and they expose pen-0 holes through which a lower-priority sprite must appear. The same layout with one axis code zeroed shows that each axis alone can hide a sprite. A sprite parked at 0xFFF8/0xFFFC tests the modular wrap. Palette rewrites, writes to the unused attribute offsets and a cycle-exact probe cover colour lookup, the ignored offsets and the two-cycle latency.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int ATTR_STRIDE_LOG2 = 3;
  localparam logic [7:0] PAL_FIRST = 8'h22;

  // magnification code 1/2/3 -> shift 0/1/2
  function automatic logic [1:0] code_to_shift(input logic [1:0] code);
    return code - 2'd1;
  endfunction
endpackage

// File: rtl/spr_cfg_regs.sv
module spr_cfg_regs
  import spr_pkg::*;
#(
  parameter int NSPR    = 16,
  parameter int COORD_W = 16,
  parameter int PEN_W   = 4,
  parameter int COL_W   = 12,
  parameter int OFF_W   = 12,
  localparam int NPEN   = 1 << PEN_W,
  localparam int SPR_W  = $clog2(NSPR)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [OFF_W-1:0]                  off,
  input  logic [7:0]                        wdata,
  output logic [NSPR-1:0][COORD_W-1:0]      pos_x,
  output logic [NSPR-1:0][COORD_W-1:0]      pos_y,
  output logic [NSPR-1:0][3:0]              mag,
  output logic [NPEN-1:0][COL_W-1:0]        pal
);
  localparam int ATTR_SPAN = NSPR << ATTR_STRIDE_LOG2;

  logic                     attr_hit, pal_hit;
  logic [SPR_W-1:0]         a_spr;
  logic [2:0]               a_byte;
  logic [PEN_W-1:0]         p_idx;

  always_comb begin
    attr_hit = we && (off < OFF_W'(ATTR_SPAN));
    a_spr    = off[SPR_W+2:3];
    a_byte   = off[2:0];
    p_idx    = off[PEN_W:1];
    pal_hit  = we && (off[OFF_W-1:8] == (OFF_W-8)'(1)) && (off[7:5] == PAL_FIRST[7:5])
               && (p_idx != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_x <= '0;
      pos_y <= '0;
      mag   <= '0;
    end else if (attr_hit) begin
      case (a_byte)
        3'd0: pos_x[a_spr][7:0]         <= wdata;
        3'd1: pos_x[a_spr][COORD_W-1:8] <= wdata[COORD_W-9:0];
        3'd2: pos_y[a_spr][7:0]         <= wdata;
        3'd3: pos_y[a_spr][COORD_W-1:8] <= wdata[COORD_W-9:0];
        3'd4: mag[a_spr]                <= wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pal <= '0;
    end else if (pal_hit) begin
      if (!off[0]) pal[p_idx][7:0]       <= wdata;
      else         pal[p_idx][COL_W-1:8] <= wdata[COL_W-9:0];
    end
  end

  a_r8_mag_needs_write: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mag));
endmodule

// File: rtl/spr_lane.sv
module spr_lane
  import spr_pkg::*;
#(
  parameter int COORD_W   = 16,
  parameter int SIZE_LOG2 = 4,
  parameter int PEN_W     = 4,
  localparam int DEPTH    = 1 << (2 * SIZE_LOG2),
  localparam int AW       = 2 * SIZE_LOG2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [PEN_W-1:0]   wr_pen,
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [3:0]         mag,
  output logic               hit_q,
  output logic [PEN_W-1:0]   pen_q
);
  logic [PEN_W-1:0]     mem [DEPTH];
  logic [COORD_W-1:0]   dx, dy, span_x, span_y;
  logic [1:0]           sh_x, sh_y;
  logic [SIZE_LOG2-1:0] col, row;
  logic                 shown, hit_d;

  always_comb begin
    shown  = (mag[3:2] != 2'd0) && (mag[1:0] != 2'd0);
    sh_x   = code_to_shift(mag[3:2]);
    sh_y   = code_to_shift(mag[1:0]);
    dx     = beam_x - pos_x;
    dy     = beam_y - pos_y;
    span_x = COORD_W'(1 << SIZE_LOG2) << sh_x;
    span_y = COORD_W'(1 << SIZE_LOG2) << sh_y;
    col    = SIZE_LOG2'(dx >> sh_x);
    row    = SIZE_LOG2'(dy >> sh_y);
    hit_d  = shown && (dx < span_x) && (dy < span_y);
  end

  // simple dual-port pixel store: one write, one synchronous read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_pen;
    pen_q <= mem[{row, col}];
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit_d;
  end

  a_r4_zero_code_hides: assert property (@(posedge clk) disable iff (rst)
    ((mag[3:2] == 2'd0) || (mag[1:0] == 2'd0)) |=> !hit_q);
endmodule

// File: rtl/spr_prio_mux.sv
module spr_prio_mux #(
  parameter int NSPR  = 16,
  parameter int PEN_W = 4,
  parameter int COL_W = 12,
  localparam int NPEN = 1 << PEN_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [NSPR-1:0]              hit,
  input  logic [NSPR-1:0][PEN_W-1:0]   pens,
  input  logic [NPEN-1:0][COL_W-1:0]   pal,
  output logic                         px_valid,
  output logic [PEN_W-1:0]             px_pen,
  output logic [COL_W-1:0]             px_colour
);
  logic [NSPR-1:0]  grant;
  logic             taken;
  logic [PEN_W-1:0] sel_pen;

  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < NSPR; i++) begin
      if (!taken && hit[i] && (pens[i] != '0)) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
    sel_pen = '0;
    for (int i = 0; i < NSPR; i++) begin
      if (grant[i]) sel_pen = pens[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      px_valid  <= 1'b0;
      px_pen    <= '0;
      px_colour <= '0;
    end else if (in_valid && taken) begin
      px_valid  <= 1'b1;
      px_pen    <= sel_pen;
      px_colour <= pal[sel_pen];
    end else begin
      px_valid  <= 1'b0;
      px_pen    <= '0;
      px_colour <= '0;
    end
  end

  a_r6_single_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  a_r5_valid_is_opaque: assert property (@(posedge clk) disable iff (rst)
    px_valid |-> (px_pen != '0));
endmodule

// File: rtl/spr_compositor.sv
module spr_compositor #(
  parameter int NSPR      = 16,
  parameter int SIZE_LOG2 = 4,
  parameter int COORD_W   = 16,
  parameter int PEN_W     = 4,
  parameter int COL_W     = 12,
  localparam int SPR_W    = $clog2(NSPR),
  localparam int PIX_AW   = SPR_W + 2 * SIZE_LOG2,
  localparam int ADDR_W   = PIX_AW + 1,
  localparam int NPEN     = 1 << PEN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic               beam_valid,
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  output logic               px_valid,
  output logic [PEN_W-1:0]   px_pen,
  output logic [COL_W-1:0]   px_colour
);
  logic [NSPR-1:0][COORD_W-1:0] pos_x, pos_y;
  logic [NSPR-1:0][3:0]         mag;
  logic [NPEN-1:0][COL_W-1:0]   pal;
  logic [NSPR-1:0]              hit_q;
  logic [NSPR-1:0][PEN_W-1:0]   pen_q;
  logic                         pix_we, reg_we, v1;

  assign pix_we = cpu_we && !cpu_addr[PIX_AW];
  assign reg_we = cpu_we &&  cpu_addr[PIX_AW];

  spr_cfg_regs #(
    .NSPR(NSPR), .COORD_W(COORD_W), .PEN_W(PEN_W), .COL_W(COL_W), .OFF_W(PIX_AW)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .off(cpu_addr[PIX_AW-1:0]), .wdata(cpu_wdata),
    .pos_x(pos_x), .pos_y(pos_y), .mag(mag), .pal(pal)
  );

  for (genvar s = 0; s < NSPR; s++) begin : g_lane
    logic sel;
    assign sel = pix_we && (cpu_addr[PIX_AW-1:2*SIZE_LOG2] == SPR_W'(s));
    spr_lane #(
      .COORD_W(COORD_W), .SIZE_LOG2(SIZE_LOG2), .PEN_W(PEN_W)
    ) u_lane (
      .clk(clk), .rst(rst), .wr_en(sel), .wr_addr(cpu_addr[2*SIZE_LOG2-1:0]),
      .wr_pen(cpu_wdata[PEN_W-1:0]), .beam_x(beam_x), .beam_y(beam_y),
      .pos_x(pos_x[s]), .pos_y(pos_y[s]), .mag(mag[s]),
      .hit_q(hit_q[s]), .pen_q(pen_q[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= beam_valid;
  end

  spr_prio_mux #(
    .NSPR(NSPR), .PEN_W(PEN_W), .COL_W(COL_W)
  ) u_mux (
    .clk(clk), .rst(rst), .in_valid(v1), .hit(hit_q), .pens(pen_q), .pal(pal),
    .px_valid(px_valid), .px_pen(px_pen), .px_colour(px_colour)
  );

  a_r10_idle_stays_dark: assert property (@(posedge clk) disable iff (rst)
    !beam_valid |=> ##1 !px_valid);
endmodule

// File: tb/sim_spr_compositor.sv
module sim_spr_compositor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        beam_valid = 1'b0;
  logic [15:0] beam_x = '0, beam_y = '0;
  logic        px_valid;
  logic [3:0]  px_pen;
  logic [11:0] px_colour;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [15:0] bx_a [16];
  logic [15:0] by_a [16];
  logic [3:0]  mg_a [16];
  logic [11:0] pal_a [16];

  always #2.5 clk = ~clk;

  spr_compositor u0 (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .beam_valid(beam_valid), .beam_x(beam_x), .beam_y(beam_y),
    .px_valid(px_valid), .px_pen(px_pen), .px_colour(px_colour)
  );

  function automatic logic [3:0] pen_of(int s, int r, int c);
    return 4'((s * 7 + r * 3 + c) % 16);
  endfunction

  function automatic void model(input logic [15:0] bx, input logic [15:0] by,
                                output logic v, output logic [3:0] p, output logic [11:0] c);
    v = 1'b0; p = '0; c = '0;
    for (int s = 15; s >= 0; s--) begin
      int xs, ys, dx, dy;
      logic [3:0] pp;
      if (mg_a[s][3:2] == 0 || mg_a[s][1:0] == 0) continue;
      xs = int'(mg_a[s][3:2]) - 1;
      ys = int'(mg_a[s][1:0]) - 1;
      dx = (int'(bx) - int'(bx_a[s])) & 16'hFFFF;
      dy = (int'(by) - int'(by_a[s])) & 16'hFFFF;
      if (dx < (16 << xs) && dy < (16 << ys)) begin
        pp = pen_of(s, dy >> ys, dx >> xs);
        if (pp != 0) begin v = 1'b1; p = pp; c = pal_a[pp]; end
      end
    end
  endfunction

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic set_attr(int s, logic [15:0] x, logic [15:0] y, logic [3:0] m);
    wr(13'h1000 + 13'(8 * s) + 0, x[7:0]);
    wr(13'h1000 + 13'(8 * s) + 1, x[15:8]);
    wr(13'h1000 + 13'(8 * s) + 2, y[7:0]);
    wr(13'h1000 + 13'(8 * s) + 3, y[15:8]);
    wr(13'h1000 + 13'(8 * s) + 4, {4'h0, m});
    bx_a[s] = x; by_a[s] = y; mg_a[s] = m;
  endtask

  task automatic set_pal(int p, logic [11:0] c);
    wr(13'h1122 + 13'(2 * (p - 1)), c[7:0]);
    wr(13'h1123 + 13'(2 * (p - 1)), {4'h0, c[11:8]});
    pal_a[p] = c;
  endtask

  task automatic chk(string tag, logic [15:0] x, logic [15:0] y,
                     logic ev, logic [3:0] ep, logic [11:0] ec);
    n_chk++;
    if (px_valid !== ev || (ev && (px_pen !== ep || px_colour !== ec))) begin
      n_bad++;
      $display("FAIL %s at (%0h,%0h): got v=%0b pen=%0h col=%0h, expected v=%0b pen=%0h col=%0h",
               tag, x, y, px_valid, px_pen, px_colour, ev, ep, ec);
    end
  endtask

  task automatic probe(logic [15:0] x, logic [15:0] y, string tag);
    logic ev; logic [3:0] ep; logic [11:0] ec;
    model(x, y, ev, ep, ec);
    @(negedge clk); beam_valid = 1'b1; beam_x = x; beam_y = y;
    @(negedge clk); beam_valid = 1'b0;
    @(negedge clk);
    chk(tag, x, y, ev, ep, ec);
  endtask

  task automatic sweep(int x0, int x1, int y0, int y1, string tag);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        probe(16'(x), 16'(y), tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      bx_a[i] = '0; by_a[i] = '0; mg_a[i] = '0;
      pal_a[i] = 12'((i * 16'h123 + 16'h0A5) & 16'hFFF);
    end
    pal_a[0] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, all hidden
    @(negedge clk);
    chk("R1", 0, 0, 1'b0, 4'h0, 12'h0);
    n_chk++;
    if (px_pen !== 4'h0 || px_colour !== 12'h0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: got pen=%0h col=%0h expected 0/0", px_pen, px_colour);
    end
    probe(16'd0, 16'd0, "R1");
    probe(16'd5, 16'd9, "R1");

    // R2: load pixel memories
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 16; c++)
          wr(13'(s * 256 + r * 16 + c), {4'hA, pen_of(s, r, c)});
    for (int p = 1; p < 16; p++) set_pal(p, pal_a[p]);

    // R2: lone unit-size sprite
    set_attr(0, 16'd4, 16'd8, 4'b0101);
    sweep(0, 27, 4, 27, "R2");

    // R10: exact two-cycle latency (pixel (5,8) -> pen 1)
    @(negedge clk); beam_valid = 1'b1; beam_x = 16'd5; beam_y = 16'd8;
    @(negedge clk); beam_valid = 1'b0;
    chk("R10 early", 5, 8, 1'b0, 4'h0, 12'h0);
    @(negedge clk);
    chk("R10", 5, 8, 1'b1, pen_of(0, 0, 1), pal_a[pen_of(0, 0, 1)]);
    @(negedge clk);
    chk("R10 idle", 5, 8, 1'b0, 4'h0, 12'h0);

    // R3, R5, R6: overlapping magnified sprites
    set_attr(3, 16'd40, 16'd10, 4'b1010);
    set_attr(1, 16'd50, 16'd20, 4'b1101);
    set_attr(0, 16'd60, 16'd15, 4'b0111);
    sweep(36, 120, 8, 82, "R3/R5/R6");

    // R4: one axis code zero hides the sprite
    set_attr(1, 16'd50, 16'd20, 4'b0001);
    set_attr(3, 16'd40, 16'd10, 4'b1000);
    sweep(36, 120, 8, 82, "R4");

    // R9: wraparound
    set_attr(0, 16'd0, 16'd0, 4'b0000);
    set_attr(5, 16'hFFF8, 16'hFFFC, 4'b0101);
    for (int j = 0; j < 24; j++)
      for (int i = 0; i < 32; i++)
        probe(16'(16'hFFF0 + i), 16'(16'hFFF8 + j), "R9");

    // R8: offsets +5..+7 ignored
    wr(13'h1000 + 13'(8 * 5) + 5, 8'hFF);
    wr(13'h1000 + 13'(8 * 5) + 6, 8'h00);
    wr(13'h1000 + 13'(8 * 5) + 7, 8'h33);
    for (int i = 0; i < 12; i++) probe(16'(16'hFFF8 + i), 16'd2, "R8");

    // R7: palette rewrite changes colour of the winning pen
    set_pal(1, 12'h9C3);
    set_pal(7, 12'h05E);
    set_pal(15, 12'hF00);
    for (int i = 0; i < 16; i++) probe(16'(16'hFFF8 + i), 16'hFFFC, "R7");
    for (int i = 0; i < 16; i++) probe(16'(16'hFFF8 + i), 16'd3, "R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule